// File: doc/BRIEF.md
# Split-Word Microsecond Timebase

This block holds a 64-bit count of microseconds since reset. The count moves forward by one on each cycle where an external tick-enable pulse is present and nothing is holding it. Software reaches the count through an APB slave with a 32-bit data path. A 64-bit value is moved in two bus accesses, one for each 32-bit half. Both directions are atomic across those two accesses.

On writes, the low half is held in a staging register. The whole count is replaced only when the high half is written. On reads, reading the low half freezes a copy of the high half at that moment, so the later high-half read matches it. A second pair of registers shows the live halves and has no side effects. A software pause bit stops the count. So can the debug-halt line of either of two processors, when a per-processor mask bit selects it.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count is zero, the pause control (offset 0x30) reads 0 and the debug-pause register (offset 0x2C) reads 0x6, meaning bit 1 and bit 2 are both set.
- R2: On each clock edge where tick_en is high and no pause condition is active, the count grows by exactly one. The carry runs through all 64 bits, and the count wraps from all ones to zero.
- R3: A write to offset 0x04 only stages the 32-bit value. The count is not changed by it.
- R4: A write to offset 0x00 loads the count with the written word as bits 63:32 and the staged word as bits 31:0. This load wins over a tick in the same cycle.
- R5: A read of offset 0x0C returns the live bits 31:0 and, at the same edge, captures the live bits 63:32 into a latch. Reads of offset 0x08 return that latch.
- R6: Reads of offset 0x24 and offset 0x28 return the live bits 63:32 and 31:0 and leave the latch unchanged.
- R7: While bit 0 of offset 0x30 is 1, the count does not advance. The register reads back the written bit.
- R8: Bit 1 of offset 0x2C masks processor 0's halt input (halt[0]). Bit 2 masks processor 1's halt input (halt[1]). A set bit together with its high halt input freezes the count. All other bits of the register read zero.
- R9: pready is always 1, so every transfer completes with zero wait states. Reads of offsets 0x00, 0x04 and any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-microsecond advance pulse |
| halt | input | NCPU (2) | Debug-halt lines, one per processor |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write direction |
| paddr | input | ADDR_W (8) | APB byte address |
| pwdata | input | DATA_W (32) | APB write data |
| prdata | output | DATA_W (32) | APB read data |
| pready | output | 1 | Transfer complete, always high |

## Verification
The bench sweeps all 32 combinations of the pause bit, the two mask bits and the two halt lines. It checks that the count advances only for the unmasked, unhalted cases. A gate with a swapped mask bit or a dropped term would freeze or run in the wrong cases. Loads are checked with a tick in the same cycle, where the wrong priority leaves a result one too high. They are also checked across the 32-bit carry and the 64-bit wrap, where a broken carry gives a torn value. The latch test makes the count roll over between a low read and the high read. A design that returns the live high word gives the rolled value, and one whose raw reads disturb the latch gives a wrong high word after a raw read.

// File: rtl/usec_tb_pkg.sv
package usec_tb_pkg;
  localparam int unsigned OFF_HI_WR  = 'h00;
  localparam int unsigned OFF_LO_WR  = 'h04;
  localparam int unsigned OFF_HI_RD  = 'h08;
  localparam int unsigned OFF_LO_RD  = 'h0C;
  localparam int unsigned OFF_RAW_HI = 'h24;
  localparam int unsigned OFF_RAW_LO = 'h28;
  localparam int unsigned OFF_DBG    = 'h2C;
  localparam int unsigned OFF_PAUSE  = 'h30;

  // Gate term for one processor: masked halt.
  function automatic logic halt_term(input logic mask_bit, input logic halt_bit);
    return mask_bit & halt_bit;
  endfunction
endpackage

// File: rtl/utb_pause_gate.sv
module utb_pause_gate #(
  parameter int NCPU = 2
) (
  input  logic            sw_pause,
  input  logic [NCPU-1:0] dbg_mask,
  input  logic [NCPU-1:0] halt,
  output logic            paused
);
  import usec_tb_pkg::*;

  logic [NCPU-1:0] cpu_hold;

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    assign cpu_hold[g] = halt_term(dbg_mask[g], halt[g]);
  end

  assign paused = sw_pause | (|cpu_hold);
endmodule

// File: rtl/utb_counter.sv
module utb_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             paused,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  logic             advance;
  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign advance = tick_en & ~paused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (load_en) count_q <= load_val;
    else if (advance) count_q <= bump(count_q);
  end

  assign count = count_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !paused && !load_en) |=> count == $past(count) + CNT_W'(1));

  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> count == $past(load_val));

  p_pause_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !load_en) |=> $stable(count));
endmodule

// File: rtl/utb_regfile.sv
module utb_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCPU   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [2*DATA_W-1:0] count,
  output logic              load_en,
  output logic [2*DATA_W-1:0] load_val,
  output logic              sw_pause,
  output logic [NCPU-1:0]   dbg_mask
);
  import usec_tb_pkg::*;

  localparam int CNT_W = 2 * DATA_W;

  logic              rd_en, wr_en;
  logic              lo_rd_hit, raw_rd_hit;
  logic [DATA_W-1:0] stage_lo;
  logic [DATA_W-1:0] hi_latch;
  logic [DATA_W-1:0] live_hi, live_lo;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  assign rd_en      = psel & penable & ~pwrite;
  assign wr_en      = psel & penable & pwrite;
  assign live_hi    = count[CNT_W-1:DATA_W];
  assign live_lo    = count[DATA_W-1:0];
  assign lo_rd_hit  = rd_en & hit(paddr, OFF_LO_RD);
  assign raw_rd_hit = rd_en & (hit(paddr, OFF_RAW_HI) | hit(paddr, OFF_RAW_LO));

  assign load_en  = wr_en & hit(paddr, OFF_HI_WR);
  assign load_val = {pwdata, stage_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo <= '0;
      hi_latch <= '0;
      sw_pause <= 1'b0;
      dbg_mask <= '1;
    end else begin
      if (wr_en && hit(paddr, OFF_LO_WR)) stage_lo <= pwdata;
      if (wr_en && hit(paddr, OFF_PAUSE)) sw_pause <= pwdata[0];
      if (wr_en && hit(paddr, OFF_DBG))   dbg_mask <= pwdata[NCPU:1];
      if (lo_rd_hit)                      hi_latch <= live_hi;
    end
  end

  always_comb begin
    prdata = '0;
    if (rd_en) begin
      if (hit(paddr, OFF_HI_RD))  prdata = hi_latch;
      if (hit(paddr, OFF_LO_RD))  prdata = live_lo;
      if (hit(paddr, OFF_RAW_HI)) prdata = live_hi;
      if (hit(paddr, OFF_RAW_LO)) prdata = live_lo;
      if (hit(paddr, OFF_DBG))    prdata = DATA_W'({dbg_mask, 1'b0});
      if (hit(paddr, OFF_PAUSE))  prdata = DATA_W'(sw_pause);
    end
  end

  p_latch_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd_hit |=> hi_latch == $past(live_hi));

  p_raw_no_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_rd_hit && !lo_rd_hit) |=> $stable(hi_latch));

  p_latch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd_hit |=> $stable(hi_latch));
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCPU   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [NCPU-1:0]   halt,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] load_val;
  logic             load_en;
  logic             sw_pause;
  logic [NCPU-1:0]  dbg_mask;
  logic             paused;

  utb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCPU(NCPU)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .count(count),
    .load_en(load_en), .load_val(load_val), .sw_pause(sw_pause), .dbg_mask(dbg_mask)
  );

  utb_pause_gate #(.NCPU(NCPU)) u_gate (
    .sw_pause(sw_pause), .dbg_mask(dbg_mask), .halt(halt), .paused(paused)
  );

  utb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .paused(paused),
    .load_en(load_en), .load_val(load_val), .count(count)
  );

  assign pready = 1'b1;

  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(halt & dbg_mask) && !load_en) |=> $stable(count));
endmodule

// File: tb/usec_timebase_test.sv
module usec_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  halt = 2'b00;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  usec_timebase uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; tick_en = tk;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; #1; d = prdata;
    checks++;
    if (pready !== 1'b1) begin
      fails++;
      $display("FAIL R9 pready actual=%b expected=1", pready);
    end
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic raw64(output logic [63:0] v);
    logic [31:0] h, l;
    rd(8'h28, l); rd(8'h24, h);
    v = {h, l};
  endtask

  task automatic load64(input logic [63:0] v);
    wr(8'h04, v[31:0]); wr(8'h00, v[63:32]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    raw64(v);        check("R1 count", v, 64'd0);
    rd(8'h30, d);    check("R1 pause", {32'd0, d}, 64'd0);
    rd(8'h2C, d);    check("R1 dbg", {32'd0, d}, 64'h6);

    // R9 write-only and unmapped read zero
    rd(8'h00, d);    check("R9 rd 0x00", {32'd0, d}, 64'd0);
    rd(8'h04, d);    check("R9 rd 0x04", {32'd0, d}, 64'd0);
    rd(8'h14, d);    check("R9 rd unmapped", {32'd0, d}, 64'd0);

    // R2 basic advance
    ticks(5); raw64(v); check("R2 five ticks", v, 64'd5);

    // R3 staging only
    wr(8'h04, 32'hDEAD_BEEF);
    raw64(v); check("R3 stage no effect", v, 64'd5);
    // R4 load
    wr(8'h00, 32'h0000_0042);
    raw64(v); check("R4 load", v, 64'h0000_0042_DEAD_BEEF);
    // R4 priority over same-cycle tick
    wr(8'h04, 32'h0000_1000);
    wr(8'h00, 32'h0000_0007, 1'b1);
    raw64(v); check("R4 load beats tick", v, 64'h0000_0007_0000_1000);

    // R2 carry across halves and full wrap
    load64(64'h0000_1234_FFFF_FFFE); ticks(3);
    raw64(v); check("R2 mid carry", v, 64'h0000_1235_0000_0001);
    load64(64'hFFFF_FFFF_FFFF_FFFF); ticks(1);
    raw64(v); check("R2 wrap", v, 64'd0);

    // R5/R6 consistent read latch
    load64(64'h0000_0005_FFFF_FFFF);
    rd(8'h0C, d); check("R5 low read", {32'd0, d}, 64'hFFFF_FFFF);
    ticks(1);
    rd(8'h08, d); check("R5 latched high", {32'd0, d}, 64'h5);
    raw64(v);     check("R6 raw live", v, 64'h0000_0006_0000_0000);
    rd(8'h08, d); check("R6 latch kept", {32'd0, d}, 64'h5);
    rd(8'h0C, d); check("R5 low read 2", {32'd0, d}, 64'd0);
    rd(8'h08, d); check("R5 latch updated", {32'd0, d}, 64'h6);

    // R7/R8 sweep of all pause conditions
    for (int k = 0; k < 32; k++) begin
      logic p, m0, m1, h0, h1, stop;
      logic [63:0] base;
      p = k[0]; m0 = k[1]; m1 = k[2]; h0 = k[3]; h1 = k[4];
      stop = p | (m0 & h0) | (m1 & h1);
      base = {32'(k), 32'hFFFF_FFF0};
      wr(8'h30, {31'd0, p});
      wr(8'h2C, {29'h1FFF_FFFF, m1, m0, 1'b1});
      rd(8'h2C, d); check("R8 dbg readback", {32'd0, d}, {59'd0, m1, m0, 1'b0});
      rd(8'h30, d); check("R7 pause readback", {32'd0, d}, {63'd0, p});
      load64(base);
      @(negedge clk); halt = {h1, h0};
      ticks(3);
      @(negedge clk); halt = 2'b00;
      raw64(v);
      check(stop ? "R7/R8 frozen" : "R2/R8 running", v, stop ? base : base + 64'd3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule